// File: doc/BRIEF.md
# Scan-List Channel Configuration Sequencer

This block holds a short list of per-conversion input configuration words in a small RAM and hands them out one at a time as conversions happen. A host builds the list through single-cycle strobes: a clear strobe empties the list, each write strobe appends the presented word at the next free slot, and a load strobe copies the first slot into the active configuration register. From then on every conversion trigger moves the active register to the following entry. The trigger can come from an external convert pulse or from an internal timer pulse. When the list ends, the next trigger returns to the top of the list.

An acquisition-clear strobe rewinds the read side to the first entry and keeps the stored words, so the same list can run again after a new load strobe. The active word is decoded into the input-mode controls for the front end. These controls are the mode code, the source of each amplifier input, and the multiplexer channel feeding each input.

Top module: `scanlist_seq`

## Requirements
- R1: A stored word is 8 bits: bits 3:0 channel number, bit 4 sense, bit 5 single-ended, bit 6 calibration, bit 7 end-of-list. After reset the active word is 0x00, which decodes as differential mode on channels 0 and 8.
- R2: A clear strobe empties the list, so the next accepted write lands in the first slot. It also disarms the read side.
- R3: Each accepted write strobe stores `wr_data` in the slot after the previous write, with no address supplied by the host.
- R4: Once a word with the end-of-list bit set has been written, or all DEPTH slots are filled, further write strobes are ignored until the next clear strobe. A write that would fall beyond the list leaves slot 0 intact.
- R5: A load strobe puts slot 0 on `act_word` one clock later. Apart from load strobes and accepted triggers, `act_word` holds its value.
- R6: A conversion trigger on `ext_conv`, `tmr_conv` or both in one cycle advances `act_word` by exactly one entry, visible one clock later.
- R7: A trigger that arrives while the active entry is the last one returns `act_word` to slot 0. The last entry is one whose end-of-list bit is set, or the last slot written since the clear (which covers a full list).
- R8: An acquisition-clear strobe rewinds the read position to slot 0. It keeps all stored words and leaves `act_word` unchanged. A later load strobe presents slot 0.
- R9: Triggers are ignored until a load strobe has occurred since the last clear or acquisition-clear strobe.
- R10: Any strobe in a cycle blocks a trigger in that same cycle. Among simultaneous strobes only one takes effect, in the order clear, acquisition-clear, load, write.
- R11: With calibration=0 and single-ended=0 the mode is differential (`in_mode`=0). Both sources are the multiplexer (`pos_src`=`neg_src`=0). `pos_chan` is channel bits 2:0 with bit 3 cleared, and `neg_chan` is the same bits with bit 3 set.
- R12: With calibration=0 and single-ended=1 the positive input is multiplexer channel `pos_chan` = channel number, and `neg_chan`=0. With sense=0 the mode is referenced (`in_mode`=1) and the negative input is ground (`neg_src`=1). With sense=1 the mode is non-referenced (`in_mode`=2) and the negative input is the sense line (`neg_src`=2).
- R13: With calibration=1 the single-ended bit is ignored. Sense=0 gives offset calibration (`in_mode`=3, both sources ground, `pos_src`=1, `neg_src`=1). Sense=1 gives gain calibration (`in_mode`=4, positive input at the internal reference `pos_src`=2, negative at ground `neg_src`=1). Both channel outputs are 0 in either calibration mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_stb | input | 1 | List clear strobe |
| wr_stb | input | 1 | List append strobe |
| wr_data | input | 8 | Word to append |
| load_stb | input | 1 | Present slot 0 and arm the read side |
| acq_clr_stb | input | 1 | Rewind read position, keep list |
| ext_conv | input | 1 | External conversion pulse |
| tmr_conv | input | 1 | Internal timer conversion pulse |
| act_word | output | 8 | Active configuration word (registered) |
| in_mode | output | 3 | Decoded input mode code |
| pos_src | output | 2 | Positive input source: 0 mux, 1 ground, 2 reference |
| neg_src | output | 2 | Negative input source: 0 mux, 1 ground, 2 sense |
| pos_chan | output | 4 | Mux channel for the positive input |
| neg_chan | output | 4 | Mux channel for the negative input |

## Verification
The hardest situation to reach is a list that ends because it fills up rather than because of a flag. A write that arrives after that point must not wrap the write position onto slot 0. The stimulus writes sixteen words with the end bit clear and then issues one more write. It then loads and triggers sixteen times, so that slot 0 comes back unaltered on both the load and the wrap. A second hard spot is a write strobe that meets a trigger in the same cycle on an armed, unterminated list. That write must block the advance and must also move the end of the list, which the later wrap position reveals.

// File: rtl/scanlist_pkg.sv
package scanlist_pkg;

  typedef enum logic [2:0] {
    MODE_DIFF    = 3'd0,
    MODE_RSE     = 3'd1,
    MODE_NRSE    = 3'd2,
    MODE_OFFCAL  = 3'd3,
    MODE_GAINCAL = 3'd4
  } in_mode_e;

  // Input source selector: AUX is the reference on the positive side,
  // the sense line on the negative side.
  typedef enum logic [1:0] {
    SRC_MUX = 2'd0,
    SRC_GND = 2'd1,
    SRC_AUX = 2'd2
  } src_e;

endpackage

// File: rtl/scanlist_ram.sv
module scanlist_ram #(
  parameter int W  = 8,
  parameter int D  = 16,
  parameter int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register with enable: holds the active word between reads.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/scanlist_wr_ctrl.sv
module scanlist_wr_ctrl #(
  parameter int D  = 16,
  parameter int AW = $clog2(D),
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic          wr_eol,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] count,
  output logic          locked
);

  assign we    = wr & ~locked;
  assign waddr = count[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count  <= '0;
      locked <= 1'b0;
    end else if (we) begin
      count  <= count + CW'(1);
      locked <= wr_eol | (count == CW'(D - 1));
    end
  end

endmodule

// File: rtl/scanlist_rd_ctrl.sv
module scanlist_rd_ctrl #(
  parameter int D  = 16,
  parameter int AW = $clog2(D),
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          acq_clr,
  input  logic          load,
  input  logic          trig,
  input  logic          act_eol,
  input  logic [CW-1:0] count,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW-1:0] rp,
  output logic          armed
);

  logic adv;
  logic end_hit;

  assign adv     = trig & armed;
  assign end_hit = act_eol | ((CW'(rp) + CW'(1)) == count);
  assign re      = load | adv;
  assign raddr   = (load || end_hit) ? '0 : rp + AW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr || acq_clr) begin
      rp    <= '0;
      armed <= 1'b0;
    end else if (load) begin
      rp    <= '0;
      armed <= 1'b1;
    end else if (adv) begin
      rp    <= raddr;
    end
  end

endmodule

// File: rtl/scanlist_mode_dec.sv
module scanlist_mode_dec
  import scanlist_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic              cal,
  input  logic              se,
  input  logic              sense,
  output logic [2:0]        in_mode,
  output logic [1:0]        pos_src,
  output logic [1:0]        neg_src,
  output logic [CHAN_W-1:0] pos_chan,
  output logic [CHAN_W-1:0] neg_chan
);

  always_comb begin
    in_mode  = MODE_DIFF;
    pos_src  = SRC_MUX;
    neg_src  = SRC_MUX;
    pos_chan = '0;
    neg_chan = '0;
    if (cal) begin
      in_mode = sense ? MODE_GAINCAL : MODE_OFFCAL;
      pos_src = sense ? SRC_AUX : SRC_GND;
      neg_src = SRC_GND;
    end else if (se) begin
      in_mode  = sense ? MODE_NRSE : MODE_RSE;
      neg_src  = sense ? SRC_AUX : SRC_GND;
      pos_chan = chan;
    end else begin
      pos_chan = {1'b0, chan[CHAN_W-2:0]};
      neg_chan = {1'b1, chan[CHAN_W-2:0]};
    end
  end

endmodule

// File: rtl/scanlist_seq.sv
module scanlist_seq #(
  parameter int DEPTH  = 16,
  parameter int CHAN_W = 4,
  localparam int WORD_W = CHAN_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_stb,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              load_stb,
  input  logic              acq_clr_stb,
  input  logic              ext_conv,
  input  logic              tmr_conv,
  output logic [WORD_W-1:0] act_word,
  output logic [2:0]        in_mode,
  output logic [1:0]        pos_src,
  output logic [1:0]        neg_src,
  output logic [CHAN_W-1:0] pos_chan,
  output logic [CHAN_W-1:0] neg_chan
);

  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = AW + 1;
  localparam int SENSE_B = CHAN_W;
  localparam int SE_B    = CHAN_W + 1;
  localparam int CAL_B   = CHAN_W + 2;
  localparam int EOL_B   = CHAN_W + 3;

  // One strobe per cycle wins; any strobe masks the trigger.
  logic s_clr, s_acq, s_load, s_wr, any_stb, trig;
  assign s_clr   = clr_stb;
  assign s_acq   = acq_clr_stb & ~clr_stb;
  assign s_load  = load_stb & ~clr_stb & ~acq_clr_stb;
  assign s_wr    = wr_stb & ~clr_stb & ~acq_clr_stb & ~load_stb;
  assign any_stb = clr_stb | acq_clr_stb | load_stb | wr_stb;
  assign trig    = (ext_conv | tmr_conv) & ~any_stb;

  logic          we, re, locked, armed;
  logic [AW-1:0] waddr, raddr, rd_ptr;
  logic [CW-1:0] count;

  scanlist_wr_ctrl #(.D(DEPTH), .AW(AW), .CW(CW)) u_wr (
    .clk    (clk),
    .rst    (rst),
    .clr    (s_clr),
    .wr     (s_wr),
    .wr_eol (wr_data[EOL_B]),
    .we     (we),
    .waddr  (waddr),
    .count  (count),
    .locked (locked)
  );

  scanlist_rd_ctrl #(.D(DEPTH), .AW(AW), .CW(CW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .clr     (s_clr),
    .acq_clr (s_acq),
    .load    (s_load),
    .trig    (trig),
    .act_eol (act_word[EOL_B]),
    .count   (count),
    .re      (re),
    .raddr   (raddr),
    .rp      (rd_ptr),
    .armed   (armed)
  );

  scanlist_ram #(.W(WORD_W), .D(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (waddr),
    .wdata (wr_data),
    .re    (re),
    .raddr (raddr),
    .rdata (act_word)
  );

  scanlist_mode_dec #(.CHAN_W(CHAN_W)) u_dec (
    .chan     (act_word[CHAN_W-1:0]),
    .cal      (act_word[CAL_B]),
    .se       (act_word[SE_B]),
    .sense    (act_word[SENSE_B]),
    .in_mode  (in_mode),
    .pos_src  (pos_src),
    .neg_src  (neg_src),
    .pos_chan (pos_chan),
    .neg_chan (neg_chan)
  );

endmodule

// File: rtl/scanlist_seq_chk.sv
module scanlist_seq_chk #(
  parameter int DEPTH  = 16,
  parameter int CHAN_W = 4,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = AW + 1,
  parameter int WORD_W = CHAN_W + 4
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_stb,
  input logic              wr_stb,
  input logic              load_stb,
  input logic              acq_clr_stb,
  input logic              ext_conv,
  input logic              tmr_conv,
  input logic [WORD_W-1:0] act_word,
  input logic [2:0]        in_mode,
  input logic [1:0]        pos_src,
  input logic [1:0]        neg_src,
  input logic [CHAN_W-1:0] neg_chan,
  input logic [CW-1:0]     count,
  input logic              locked,
  input logic [AW-1:0]     rd_ptr,
  input logic              armed
);

  logic stb_any;
  assign stb_any = clr_stb | wr_stb | load_stb | acq_clr_stb;

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (locked && !clr_stb) |=> count == $past(count));

  assert_clr_empty_R2: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> (count == '0) && !armed);

  assert_load_rewind_R5: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !clr_stb && !acq_clr_stb) |=> (rd_ptr == '0) && armed);

  assert_acq_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (acq_clr_stb && !clr_stb) |=> (rd_ptr == '0) && $stable(act_word)
                                  && count == $past(count));

  assert_idle_trig_R9: assert property (@(posedge clk) disable iff (rst)
    (!armed && (ext_conv || tmr_conv) && !stb_any) |=> $stable(act_word));

  assert_wr_blocks_trig_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !clr_stb && !acq_clr_stb && !load_stb && (ext_conv || tmr_conv))
      |=> $stable(act_word));

  assert_diff_banks_R11: assert property (@(posedge clk) disable iff (rst)
    (in_mode == 3'd0) |-> neg_chan[CHAN_W-1] && pos_src == 2'd0);

  assert_cal_sources_R13: assert property (@(posedge clk) disable iff (rst)
    act_word[CHAN_W+2] |-> (pos_src != 2'd0) && (neg_src == 2'd1));

endmodule

bind scanlist_seq scanlist_seq_chk #(.DEPTH(DEPTH), .CHAN_W(CHAN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr_stb     (clr_stb),
  .wr_stb      (wr_stb),
  .load_stb    (load_stb),
  .acq_clr_stb (acq_clr_stb),
  .ext_conv    (ext_conv),
  .tmr_conv    (tmr_conv),
  .act_word    (act_word),
  .in_mode     (in_mode),
  .pos_src     (pos_src),
  .neg_src     (neg_src),
  .neg_chan    (neg_chan),
  .count       (count),
  .locked      (locked),
  .rd_ptr      (rd_ptr),
  .armed       (armed)
);

// File: tb/scanlist_seq_test.sv
module scanlist_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr_stb = 0, wr_stb = 0, load_stb = 0, acq_clr_stb = 0;
  logic       ext_conv = 0, tmr_conv = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] act_word;
  logic [2:0] in_mode;
  logic [1:0] pos_src, neg_src;
  logic [3:0] pos_chan, neg_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanlist_seq uut (
    .clk(clk), .rst(rst), .clr_stb(clr_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .load_stb(load_stb), .acq_clr_stb(acq_clr_stb), .ext_conv(ext_conv),
    .tmr_conv(tmr_conv), .act_word(act_word), .in_mode(in_mode),
    .pos_src(pos_src), .neg_src(neg_src), .pos_chan(pos_chan), .neg_chan(neg_chan)
  );

  int tests = 0;
  int fails = 0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  // Reference model built from the requirements
  logic [7:0] m_mem [DEPTH];
  int         m_count = 0;
  bit         m_locked = 0;
  int         m_rp = 0;
  bit         m_armed = 0;
  logic [7:0] m_act = '0;

  function automatic logic [14:0] exp_dec(input logic [7:0] w);
    logic [2:0] m; logic [1:0] p, n; logic [3:0] pc, nc;
    pc = '0; nc = '0; p = 2'd0; n = 2'd0;
    if (w[6]) begin
      m = w[4] ? 3'd4 : 3'd3;
      p = w[4] ? 2'd2 : 2'd1;
      n = 2'd1;
    end else if (w[5]) begin
      m  = w[4] ? 3'd2 : 3'd1;
      n  = w[4] ? 2'd2 : 2'd1;
      pc = w[3:0];
    end else begin
      m  = 3'd0;
      pc = {1'b0, w[2:0]};
      nc = {1'b1, w[2:0]};
    end
    return {m, p, n, pc, nc};
  endfunction

  // Driver: one cycle of stimulus, model update, expectation pushed
  task automatic step(input bit c, input bit w, input logic [7:0] d, input bit l,
                      input bit a, input bit e, input bit t, input string req);
    @(negedge clk);
    clr_stb = c; wr_stb = w; wr_data = d; load_stb = l;
    acq_clr_stb = a; ext_conv = e; tmr_conv = t;
    @(posedge clk);
    #1;
    clr_stb = 0; wr_stb = 0; load_stb = 0; acq_clr_stb = 0;
    ext_conv = 0; tmr_conv = 0;
    if (c) begin
      m_count = 0; m_locked = 0; m_rp = 0; m_armed = 0;
    end else if (a) begin
      m_rp = 0; m_armed = 0;
    end else if (l) begin
      m_rp = 0; m_armed = 1; m_act = m_mem[0];
    end else if (w) begin
      if (!m_locked) begin
        m_mem[m_count] = d;
        m_count++;
        if (d[7] || m_count == DEPTH) m_locked = 1;
      end
    end else if ((e || t) && m_armed) begin
      if (m_act[7] || m_rp + 1 == m_count) m_rp = 0;
      else m_rp++;
      m_act = m_mem[m_rp];
    end
    exp_q.push_back(m_act);
    req_q.push_back(req);
  endtask

  task automatic wr(input logic [7:0] d, input string req);
    step(0, 1, d, 0, 0, 0, 0, req);
  endtask
  task automatic conv(input bit e, input bit t, input string req);
    step(0, 0, 8'h00, 0, 0, e, t, req);
  endtask

  // Monitor: compares the outputs with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [7:0] ew; string rq; logic [14:0] ed, ad;
        ew = exp_q.pop_front();
        rq = req_q.pop_front();
        ed = exp_dec(ew);
        ad = {in_mode, pos_src, neg_src, pos_chan, neg_chan};
        tests++;
        if (act_word !== ew || ad !== ed) begin
          fails++;
          $display("FAIL %s: act_word=%h dec=%h expected act_word=%h dec=%h",
                   rq, act_word, ad, ew, ed);
        end
      end
    end
  end

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    exp_q.push_back(8'h00); req_q.push_back("R1 reset state");

    // List 1: five entries, end flag on the fifth
    step(1, 0, 8'h00, 0, 0, 0, 0, "R2 clear");
    wr(8'h03, "R3 first write");
    conv(1, 0, "R9 trigger before load ignored");
    wr(8'h25, "R3 write"); wr(8'h3A, "R3 write");
    wr(8'h40, "R3 write"); wr(8'hD0, "R3 write with end flag");
    step(0, 0, 8'h00, 1, 0, 0, 0, "R5 load presents slot 0, R11 diff");
    conv(1, 0, "R6 ext trigger, R12 referenced");
    conv(0, 1, "R6 timer trigger, R12 non-referenced");
    conv(1, 1, "R6 both triggers one step, R13 offset cal");
    conv(1, 0, "R6 advance, R13 gain cal");
    conv(1, 0, "R7 wrap on end flag");
    wr(8'h11, "R4 write after end flag ignored");
    conv(1, 0, "R6 advance");
    step(0, 0, 8'h00, 0, 1, 0, 0, "R8 acq clear holds output");
    conv(1, 0, "R9 trigger after acq clear ignored");
    step(0, 0, 8'h00, 1, 0, 0, 0, "R8 reload after acq clear");
    conv(1, 0, "R8 entries intact");
    step(0, 0, 8'h00, 1, 0, 1, 0, "R10 load beats trigger");
    step(0, 0, 8'h00, 1, 1, 0, 0, "R10 acq clear beats load");
    conv(0, 1, "R10 disarmed after acq clear");
    step(0, 0, 8'h00, 1, 0, 0, 0, "R5 load");

    // List 2: no end flag, extended while armed
    step(1, 0, 8'h00, 0, 0, 0, 0, "R2 clear second list");
    conv(1, 0, "R2 clear disarms");
    wr(8'h27, "R3"); wr(8'h08, "R3"); wr(8'h36, "R3");
    step(0, 0, 8'h00, 1, 0, 0, 0, "R2 new list starts at slot 0");
    step(0, 1, 8'h5F, 0, 0, 1, 0, "R10 write blocks trigger");
    conv(1, 0, "R11 diff ch0/ch8");
    conv(1, 0, "R12 non-referenced");
    conv(0, 1, "R13 gain cal with channel bits set");
    conv(1, 0, "R7 wrap after last written slot");

    // List 3: full list, one extra write
    step(1, 0, 8'h00, 0, 0, 0, 0, "R2 clear third list");
    for (int i = 0; i < DEPTH; i++)
      wr(((i % 2) == 0) ? (8'h20 | 8'(i)) : 8'(i), "R3 fill");
    wr(8'hFF, "R4 write beyond full ignored");
    step(0, 0, 8'h00, 1, 0, 0, 0, "R4 slot 0 not overwritten");
    for (int i = 1; i < DEPTH; i++) conv(1, 0, "R6 walk full list");
    conv(1, 0, "R7 wrap after full list");

    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule